// File: doc/BRIEF.md
# Integer Min/Max, Average and Absolute-Difference Unit

A purely combinational integer datapath of configurable width. It takes two source operands, an accumulator operand and a 4-bit operation code. It returns one result word. The operations are:

- signed and unsigned maximum and minimum
- a rounding-up average of unsigned operands
- signed and unsigned absolute difference
- two accumulating absolute-difference forms that add onto the accumulator operand
- a carry-propagate combine that treats one operand as propagate bits and the other as generate bits

A record enable selects what the unit does with a 4-bit condition field. When it is set, the unit builds the field from the result. When it is clear, the unit passes the incoming field through unchanged. The unit holds no state. A surrounding pipeline supplies registers and operand routing.

Top module: `mmad_alu`

## Requirements
- R1: Operation code 0 returns op_a if op_a is greater than op_b, otherwise op_b. Code 2 returns op_a if op_a is less than op_b, otherwise op_b. Both compares treat the operands as two's-complement signed.
- R2: Codes 1 and 3 are the same maximum and minimum with an unsigned compare.
- R3: Code 4 returns bits [XLEN:1] of the (XLEN+1)-bit sum op_a + op_b + 1, with both operands zero-extended. The average of two all-ones operands is therefore all-ones.
- R4: Code 5 (signed compare) and code 6 (unsigned compare) return op_b − op_a when op_a < op_b, otherwise op_a − op_b. Both are taken modulo 2^XLEN.
- R5: Code 7 returns acc_t plus the unsigned absolute difference. Code 8 returns acc_t plus the signed absolute difference. Both wrap modulo 2^XLEN.
- R6: Code 9 returns ((op_a | op_b) + op_b) XOR op_a.
- R7: Codes 10 to 15 return an all-zero result.
- R8: With rec_en high, cond_out[3] is set when the result is negative as signed, cond_out[2] when it is positive, and cond_out[1] when it is zero. Exactly one of these three bits is set. cond_out[0] equals so_in.
- R9: With rec_en low, cond_out equals cond_in whatever the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | XLEN | First source operand (propagate bits for code 9) |
| op_b | input | XLEN | Second source operand (generate bits for code 9) |
| acc_t | input | XLEN | Accumulator operand for codes 7 and 8 |
| op_sel | input | 4 | Operation code |
| rec_en | input | 1 | Build the condition field from the result |
| so_in | input | 1 | Summary-overflow bit copied into cond_out[0] |
| cond_in | input | 4 | Condition field passed through when rec_en is low |
| result | output | XLEN | Operation result |
| cond_out | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
The bench builds two copies of the unit, one at the default width of 64 and one at 8 bits. Both copies are fed the same sequence of operation codes through registered stages. Each width receives its own corner operands: zero, one, all-ones, the most-negative and most-positive signed values, and a mixed pattern. These cover equal operands, signed/unsigned compare disagreement and the all-ones average at both widths. At 8 bits, the random vectors also reach carry and wrap cases of the accumulate and carry-propagate codes much more densely than at 64 bits.

// File: rtl/mmad_alu.sv
module mmad_alu #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [XLEN-1:0] acc_t,
  input  logic [3:0]      op_sel,
  input  logic            rec_en,
  input  logic            so_in,
  input  logic [3:0]      cond_in,
  output logic [XLEN-1:0] result,
  output logic [3:0]      cond_out
);
  localparam logic [3:0] OP_MAXS = 4'd0, OP_MAXU = 4'd1, OP_MINS = 4'd2, OP_MINU = 4'd3,
                         OP_AVG  = 4'd4, OP_ADS  = 4'd5, OP_ADU  = 4'd6, OP_ACU  = 4'd7,
                         OP_ACS  = 4'd8, OP_CPR  = 4'd9;
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  logic            lt_s, lt_u, gt_s, gt_u, diff_lt, neg, zero;
  logic [XLEN:0]   avg_sum;
  logic [XLEN-1:0] diff;

  assign lt_s = $signed(op_a) < $signed(op_b);
  assign gt_s = $signed(op_a) > $signed(op_b);
  assign lt_u = op_a < op_b;
  assign gt_u = op_a > op_b;

  assign diff_lt = (op_sel == OP_ADS || op_sel == OP_ACS) ? lt_s : lt_u;
  assign diff    = diff_lt ? (~op_a + op_b + ONE) : (~op_b + op_a + ONE);
  assign avg_sum = {1'b0, op_a} + {1'b0, op_b} + {{XLEN{1'b0}}, 1'b1};

  always_comb begin
    case (op_sel)
      OP_MAXS: result = gt_s ? op_a : op_b;
      OP_MAXU: result = gt_u ? op_a : op_b;
      OP_MINS: result = lt_s ? op_a : op_b;
      OP_MINU: result = lt_u ? op_a : op_b;
      OP_AVG:  result = avg_sum[XLEN:1];
      OP_ADS,
      OP_ADU:  result = diff;
      OP_ACU,
      OP_ACS:  result = acc_t + diff;
      OP_CPR:  result = ((op_a | op_b) + op_b) ^ op_a;
      default: result = '0;
    endcase
  end

  assign neg      = result[XLEN-1];
  assign zero     = (result == '0);
  assign cond_out = rec_en ? {neg, ~neg & ~zero, zero, so_in} : cond_in;
endmodule

// File: rtl/mmad_alu_chk.sv
module mmad_alu_chk #(
  parameter int XLEN = 64
) (
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic [XLEN-1:0] acc_t,
  input logic [3:0]      op_sel,
  input logic            rec_en,
  input logic            so_in,
  input logic [3:0]      cond_in,
  input logic [XLEN-1:0] result,
  input logic [3:0]      cond_out
);
  logic [XLEN-1:0] mx_u, mn_u;
  assign mx_u = (op_a > op_b) ? op_a : op_b;
  assign mn_u = (op_a > op_b) ? op_b : op_a;

  always_comb begin
    if (op_sel == 4'd0)
      p_max_signed_r1: assert ((result == op_a || result == op_b) &&
                               !($signed(result) < $signed(op_a)) &&
                               !($signed(result) < $signed(op_b)));
    if (op_sel == 4'd3)
      p_min_unsigned_r2: assert ((result == op_a || result == op_b) &&
                                 result <= op_a && result <= op_b);
    if (op_sel == 4'd4)
      p_avg_bounds_r3: assert (result >= mn_u && result <= mx_u);
    if (op_sel == 4'd6)
      p_absdu_sum_r4: assert (result + mn_u == mx_u);
    if (op_sel >= 4'd10)
      p_unused_zero_r7: assert (result == '0);
    if (rec_en)
      p_cond_onehot_r8: assert ($countones(cond_out[3:1]) == 1 && cond_out[0] == so_in);
    if (!rec_en)
      p_cond_hold_r9: assert (cond_out == cond_in);
  end
endmodule

bind mmad_alu mmad_alu_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/mmad_alu_tb.sv
`timescale 1ns/1ps
module mmad_alu_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [63:0] r64; logic [3:0] c64;
    logic [7:0]  r8;  logic [3:0] c8;
    string tag;
  } item_t;
  item_t sb_q[$];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // driver-side stimulus, then registered wrapper stages
  logic [63:0] s_a, s_b, s_t, r_a, r_b, r_t;
  logic [7:0]  s_a8, s_b8, s_t8, r_a8, r_b8, r_t8;
  logic [3:0]  s_op, r_op, s_ci, r_ci;
  logic        s_rec, r_rec, s_so, r_so, s_vld = 1'b0, r_vld, o_vld;
  logic [63:0] res64, o_r64;
  logic [7:0]  res8, o_r8;
  logic [3:0]  c64, c8, o_c64, o_c8;

  always @(posedge clk) begin
    r_a <= s_a; r_b <= s_b; r_t <= s_t; r_a8 <= s_a8; r_b8 <= s_b8; r_t8 <= s_t8;
    r_op <= s_op; r_ci <= s_ci; r_rec <= s_rec; r_so <= s_so;
    o_r64 <= res64; o_c64 <= c64; o_r8 <= res8; o_c8 <= c8;
    if (!rst_n) begin r_vld <= 1'b0; o_vld <= 1'b0; end
    else begin r_vld <= s_vld; o_vld <= r_vld; end
  end

  mmad_alu #(.XLEN(64)) u_dut (
    .op_a(r_a), .op_b(r_b), .acc_t(r_t), .op_sel(r_op), .rec_en(r_rec),
    .so_in(r_so), .cond_in(r_ci), .result(res64), .cond_out(c64));

  mmad_alu #(.XLEN(8)) u_dut8 (
    .op_a(r_a8), .op_b(r_b8), .acc_t(r_t8), .op_sel(r_op), .rec_en(r_rec),
    .so_in(r_so), .cond_in(r_ci), .result(res8), .cond_out(c8));

  function automatic logic [63:0] mdl(input logic [3:0] op, input logic [63:0] a, b, t, input int w);
    logic [63:0] m, du, ds, r;
    logic signed [63:0] sa, sb;
    logic [64:0] s;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    sa = $signed(a << (64 - w)) >>> (64 - w);
    sb = $signed(b << (64 - w)) >>> (64 - w);
    du = (a < b) ? b - a : a - b;
    ds = (sa < sb) ? b - a : a - b;
    s  = {1'b0, a} + {1'b0, b} + 65'd1;
    case (op)
      4'd0: r = (sa > sb) ? a : b;
      4'd1: r = (a > b) ? a : b;
      4'd2: r = (sa < sb) ? a : b;
      4'd3: r = (a < b) ? a : b;
      4'd4: r = s[64:1];
      4'd5: r = ds;
      4'd6: r = du;
      4'd7: r = t + du;
      4'd8: r = t + ds;
      4'd9: r = ((a | b) + b) ^ a;
      default: r = '0;
    endcase
    return r & m;
  endfunction

  function automatic logic [3:0] cmdl(input logic [63:0] r, input int w, input logic rec, so, input logic [3:0] ci);
    logic n, z;
    n = r[w-1];
    z = (r == 64'd0);
    return rec ? {n, !n && !z, z, so} : ci;
  endfunction

  function automatic logic [63:0] corner(input int i, input int w);
    logic [63:0] m;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    case (i)
      0: return 64'd0;
      1: return 64'd1;
      2: return m;
      3: return 64'd1 << (w - 1);
      4: return m >> 1;
      5: return 64'hA5C3_9E17_0F5A_3C69 & m;
      default: return (m - 64'd4) & m;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic rec);
    string s;
    case (op)
      4'd0, 4'd2: s = "R1";
      4'd1, 4'd3: s = "R2";
      4'd4: s = "R3";
      4'd5, 4'd6: s = "R4";
      4'd7, 4'd8: s = "R5";
      4'd9: s = "R6";
      default: s = "R7";
    endcase
    return {s, rec ? "/R8" : "/R9"};
  endfunction

  task automatic send(input logic [3:0] op, input logic [63:0] a, b, t,
                      input logic [7:0] a8, b8, t8, input logic rec, so, input logic [3:0] ci);
    item_t it;
    it.r64 = mdl(op, a, b, t, 64);
    it.c64 = cmdl(it.r64, 64, rec, so, ci);
    it.r8  = mdl(op, {56'd0, a8}, {56'd0, b8}, {56'd0, t8}, 8) & 64'hFF;
    it.c8  = cmdl({56'd0, it.r8}, 8, rec, so, ci);
    it.tag = tag_of(op, rec);
    @(negedge clk);
    sb_q.push_back(it);
    s_vld = 1'b1; s_op = op; s_a = a; s_b = b; s_t = t;
    s_a8 = a8; s_b8 = b8; s_t8 = t8; s_rec = rec; s_so = so; s_ci = ci;
  endtask

  always @(negedge clk) begin
    if (o_vld) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: result with no expected item, actual=%h expected=none", o_r64);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        checks += 4;
        if (o_r64 !== it.r64) begin errors++;
          $display("FAIL %s result XLEN=64 actual=%h expected=%h", it.tag, o_r64, it.r64); end
        if (o_c64 !== it.c64) begin errors++;
          $display("FAIL %s cond XLEN=64 actual=%b expected=%b", it.tag, o_c64, it.c64); end
        if (o_r8 !== it.r8) begin errors++;
          $display("FAIL %s result XLEN=8 actual=%h expected=%h", it.tag, o_r8, it.r8); end
        if (o_c8 !== it.c8) begin errors++;
          $display("FAIL %s cond XLEN=8 actual=%b expected=%b", it.tag, o_c8, it.c8); end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    s_op = '0; s_a = '0; s_b = '0; s_t = '0; s_a8 = '0; s_b8 = '0; s_t8 = '0;
    s_rec = 1'b0; s_so = 1'b0; s_ci = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (o_vld !== 1'b0 || r_vld !== 1'b0) begin errors++;
      $display("FAIL reset: wrapper valid actual=%b expected=0", o_vld); end
    rst_n = 1'b1;

    // corner sweep: every code, every corner pair, both widths (R1..R9)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++) begin
          logic rec;
          rec = ((i + j + op) % 3) != 0;
          send(4'(op), corner(i, 64), corner(j, 64), corner((i + j) % 7, 64),
               corner(i, 8) & 8'hFF, corner(j, 8) & 8'hFF, corner((i + j) % 7, 8) & 8'hFF,
               rec, 1'((i ^ j) & 1), 4'(i * 5 + j));
        end

    // R3: average of two maximum values stays all-ones
    send(4'd4, '1, '1, '0, 8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0, 4'h0);
    // R5: accumulate wrap
    send(4'd7, 64'd0, 64'd3, '1, 8'd0, 8'd3, 8'hFF, 1'b1, 1'b1, 4'h0);
    // R9: condition field untouched by a zero result
    send(4'd12, 64'd5, 64'd6, 64'd0, 8'd5, 8'd6, 8'd0, 1'b0, 1'b1, 4'b1010);

    // random vectors over all codes
    for (int k = 0; k < 400; k++) begin
      logic [63:0] a, b, t;
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; t = {$urandom, $urandom};
      send(4'($urandom % 16), a, b, t, a[7:0], b[15:8], t[7:0],
           1'($urandom), 1'($urandom), 4'($urandom));
    end

    @(negedge clk) s_vld = 1'b0;
    repeat (5) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin errors++;
      $display("FAIL scoreboard drain: pending actual=%0d expected=0", sb_q.size()); end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule